// File: doc/BRIEF.md
# Power-Up Status and Address Selector

This block tracks how far the supply has come up and decides, from that, what the rest of the device may do. Two comparator inputs arrive from outside: `dig_ok` says the supply is above the level where digital logic works, and `ana_ok` says it is above the level where analog circuits and nonvolatile recall work. While `dig_ok` is low, the whole block is held in reset and the serial interface stays disabled. Once it is high, the serial slave runs. Stored settings are fetched only after `ana_ok` also rises. A delay then passes before the active-low ready bit clears, and that clearing marks the start of conversions.

The block also picks the slave addresses. Until the first recall finishes, the main slave answers at the fixed 7-bit address 0x51 (8-bit A2h) and the auxiliary slave at 0x50 (8-bit A0h) is always enabled. After recall, the main address may come from storage and single-device mode may turn the auxiliary slave off. A low-supply alarm bit (bit 4 of the alarm status byte) reads 1 from power-up until the first supply conversion reports. After that, it holds the latest comparison result.

The sequencer has five states: OFF, DIGITAL_ONLY, RECALLING, WAIT_READY and READY. OFF steps to DIGITAL_ONLY on the first clock after reset. DIGITAL_ONLY goes to RECALLING when `ana_ok` is high. RECALLING goes to WAIT_READY on `recall_done`. WAIT_READY goes to READY once its delay counter expires. From RECALLING, WAIT_READY or READY, a low `ana_ok` returns the sequencer to DIGITAL_ONLY. A low `dig_ok` forces OFF from any state.

Top module: `supply_ready_ctrl`

## Requirements
- R1: While `dig_ok` is low, the outputs are held as follows: `dbg_state` = 0 (OFF), `recall_req` = 0, `ready_n` = 1, `iface_en` = 0, `vcc_lo_flag` = 1, `main_addr` = 0x51 and `aux_en` = 1.
- R2: On the first clock edge after `dig_ok` rises, the state goes to DIGITAL_ONLY and `iface_en` goes to 1. The state stays in DIGITAL_ONLY, with `recall_req` = 0, for as long as `ana_ok` is low.
- R3: In DIGITAL_ONLY, a clock edge with `ana_ok` high moves the state to RECALLING. `recall_req` is 1 exactly while the state is RECALLING, and a clock edge with `recall_done` high moves the state to WAIT_READY.
- R4: If `recall_done` is sampled at clock edge k, `ready_n` stays 1 through edge k+READY_DELAY-1 and becomes 0 at edge k+READY_DELAY, when the state becomes READY (default READY_DELAY = 1024).
- R5: From RECALLING, WAIT_READY or READY, a clock edge with `ana_ok` low returns the state to DIGITAL_ONLY. `ready_n` is then 1, and a later return of `ana_ok` requests recall again.
- R6: With `addr_from_store` = 0, `main_addr` is 0x51. With `addr_from_store` = 1, it is 0x51 until the first `recall_done` and `stored_addr` after that. This stays true across drops of `ana_ok` and ends only when `dig_ok` goes low.
- R7: `aux_en` is 1 until the first `recall_done` regardless of `single_dev`, and afterwards equals the inverse of `single_dev`.
- R8: `vcc_lo_flag` is 1 from reset until the first `conv_done` in READY. At each clock edge where `conv_done` is high in READY, it loads `supply_low_cmp`. A `conv_done` in any other state, and a change of `supply_low_cmp` without `conv_done`, leave it unchanged.
- R9: `dbg_state` encodes OFF=0, DIGITAL_ONLY=1, RECALLING=2, WAIT_READY=3 and READY=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| dig_ok | input | 1 | Digital power-on comparator; low holds the block in reset |
| ana_ok | input | 1 | Analog power-on comparator |
| recall_done | input | 1 | Strobe: nonvolatile recall finished |
| conv_done | input | 1 | Strobe: a supply conversion finished |
| supply_low_cmp | input | 1 | Result of the supply conversion, 1 = below alarm threshold |
| addr_from_store | input | 1 | Selects the stored main address after recall |
| single_dev | input | 1 | Recalled single-device mode, disables the auxiliary slave |
| stored_addr | input | 7 | Recalled main slave address |
| recall_req | output | 1 | Request to load nonvolatile settings |
| ready_n | output | 1 | Active-low ready status bit |
| vcc_lo_flag | output | 1 | Low-supply alarm flag |
| main_addr | output | 7 | Address the main slave answers |
| aux_en | output | 1 | Auxiliary slave (0x50) enabled |
| iface_en | output | 1 | Serial interface enabled |
| dbg_state | output | 3 | Current sequencer state |

## Verification
The hardest situation to reach is a supply dip that happens after settings have been recalled. In that case the recalled address must survive while the ready bit and the recall request restart. The stimulus completes a full recall and reaches READY. It then drops `ana_ok` from each of RECALLING, WAIT_READY and READY in turn, and checks `main_addr`, `aux_en` and the state after each drop. Only a later low on `dig_ok` should bring the default address back. The 1024-cycle delay is counted from the edge where `recall_done` is sampled, and both edges on either side of the expiry are checked.

// File: rtl/supply_ready_pkg.sv
package supply_ready_pkg;

    typedef enum logic [2:0] {
        ST_OFF          = 3'd0,
        ST_DIGITAL_ONLY = 3'd1,
        ST_RECALLING    = 3'd2,
        ST_WAIT_READY   = 3'd3,
        ST_READY        = 3'd4
    } pwr_state_e;

    localparam int unsigned SLV_ADDR_W = 7;
    localparam logic [SLV_ADDR_W-1:0] MAIN_DEFAULT_ADDR = 7'h51;
    localparam logic [SLV_ADDR_W-1:0] AUX_FIXED_ADDR    = 7'h50;

endpackage

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import supply_ready_pkg::*;
#(
    parameter int unsigned READY_DELAY = 1024
) (
    input  logic       clk,
    input  logic       dig_ok,
    input  logic       ana_ok,
    input  logic       recall_done,
    output pwr_state_e state_q,
    output logic       recalled_q
);
    localparam int unsigned CNT_W = $clog2(READY_DELAY + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(READY_DELAY - 1);

    pwr_state_e       state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             cnt_done;

    assign cnt_done = (cnt_q == CNT_LAST);

    // state register
    always_ff @(posedge clk or negedge dig_ok) begin
        if (!dig_ok) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:          state_d = ST_DIGITAL_ONLY;
            ST_DIGITAL_ONLY: if (ana_ok) state_d = ST_RECALLING;
            ST_RECALLING: begin
                if (!ana_ok)          state_d = ST_DIGITAL_ONLY;
                else if (recall_done) state_d = ST_WAIT_READY;
            end
            ST_WAIT_READY: begin
                if (!ana_ok)       state_d = ST_DIGITAL_ONLY;
                else if (cnt_done) state_d = ST_READY;
            end
            ST_READY:        if (!ana_ok) state_d = ST_DIGITAL_ONLY;
            default:         state_d = ST_OFF;
        endcase
    end

    // delay counter, cleared outside WAIT_READY
    always_ff @(posedge clk or negedge dig_ok) begin
        if (!dig_ok) begin
            cnt_q <= '0;
        end else if (state_q == ST_WAIT_READY && !cnt_done) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (state_q != ST_WAIT_READY) begin
            cnt_q <= '0;
        end
    end

    // recalled settings remain valid until digital power is lost
    always_ff @(posedge clk or negedge dig_ok) begin
        if (!dig_ok) begin
            recalled_q <= 1'b0;
        end else if (state_q == ST_RECALLING && ana_ok && recall_done) begin
            recalled_q <= 1'b1;
        end
    end

endmodule

// File: rtl/slave_addr_select.sv
module slave_addr_select
    import supply_ready_pkg::*;
#(
    parameter int unsigned ADDR_W = SLV_ADDR_W
) (
    input  logic              recalled,
    input  logic              addr_from_store,
    input  logic              single_dev,
    input  logic [ADDR_W-1:0] stored_addr,
    output logic [ADDR_W-1:0] main_addr,
    output logic              aux_en
);
    always_comb begin
        if (recalled && addr_from_store) begin
            main_addr = stored_addr;
        end else begin
            main_addr = ADDR_W'(MAIN_DEFAULT_ADDR);
        end
        aux_en = !recalled || !single_dev;
    end

endmodule

// File: rtl/supply_alarm_flag.sv
module supply_alarm_flag (
    input  logic clk,
    input  logic dig_ok,
    input  logic capture_en,
    input  logic cmp_low,
    output logic flag_q
);
    always_ff @(posedge clk or negedge dig_ok) begin
        if (!dig_ok) begin
            flag_q <= 1'b1;
        end else if (capture_en) begin
            flag_q <= cmp_low;
        end
    end

endmodule

// File: rtl/supply_ready_ctrl.sv
module supply_ready_ctrl
    import supply_ready_pkg::*;
#(
    parameter int unsigned READY_DELAY = 1024,
    parameter int unsigned ADDR_W      = SLV_ADDR_W
) (
    input  logic              clk,
    input  logic              dig_ok,
    input  logic              ana_ok,
    input  logic              recall_done,
    input  logic              conv_done,
    input  logic              supply_low_cmp,
    input  logic              addr_from_store,
    input  logic              single_dev,
    input  logic [ADDR_W-1:0] stored_addr,
    output logic              recall_req,
    output logic              ready_n,
    output logic              vcc_lo_flag,
    output logic [ADDR_W-1:0] main_addr,
    output logic              aux_en,
    output logic              iface_en,
    output logic [2:0]        dbg_state
);
    pwr_state_e state_q;
    logic       recalled_q;
    logic       capture_en;

    pwr_seq_fsm #(
        .READY_DELAY (READY_DELAY)
    ) i_fsm (
        .clk         (clk),
        .dig_ok      (dig_ok),
        .ana_ok      (ana_ok),
        .recall_done (recall_done),
        .state_q     (state_q),
        .recalled_q  (recalled_q)
    );

    slave_addr_select #(
        .ADDR_W (ADDR_W)
    ) i_addr (
        .recalled        (recalled_q),
        .addr_from_store (addr_from_store),
        .single_dev      (single_dev),
        .stored_addr     (stored_addr),
        .main_addr       (main_addr),
        .aux_en          (aux_en)
    );

    supply_alarm_flag i_alarm (
        .clk        (clk),
        .dig_ok     (dig_ok),
        .capture_en (capture_en),
        .cmp_low    (supply_low_cmp),
        .flag_q     (vcc_lo_flag)
    );

    // output decode
    always_comb begin
        recall_req = 1'b0;
        ready_n    = 1'b1;
        iface_en   = 1'b1;
        capture_en = 1'b0;
        unique case (state_q)
            ST_OFF:          iface_en = 1'b0;
            ST_DIGITAL_ONLY: ;
            ST_RECALLING:    recall_req = 1'b1;
            ST_WAIT_READY:   ;
            ST_READY: begin
                ready_n    = 1'b0;
                capture_en = conv_done;
            end
            default:         iface_en = 1'b0;
        endcase
        dbg_state = state_q;
    end

endmodule

// File: rtl/chk_supply_ready_ctrl.sv
module chk_supply_ready_ctrl (
    input logic       clk,
    input logic       dig_ok,
    input logic       ana_ok,
    input logic       conv_done,
    input logic       recall_req,
    input logic       ready_n,
    input logic       vcc_lo_flag,
    input logic [6:0] main_addr,
    input logic       aux_en,
    input logic [2:0] dbg_state
);
    AST_NO_RECALL_WITHOUT_ANA: assert property (@(posedge clk) disable iff (!dig_ok)
        !ana_ok |=> !recall_req); // R3

    AST_READY_DROPS_WITH_ANA: assert property (@(posedge clk) disable iff (!dig_ok)
        !ana_ok |=> ready_n); // R5

    AST_READY_ONLY_FROM_WAIT: assert property (@(posedge clk) disable iff (!dig_ok)
        $fell(ready_n) |-> $past(dbg_state) == 3'd3); // R4

    AST_DEFAULTS_IN_OFF: assert property (@(posedge clk) disable iff (!dig_ok)
        dbg_state == 3'd0 |-> (aux_en && main_addr == 7'h51)); // R7

    AST_FLAG_HOLDS_WITHOUT_CONV: assert property (@(posedge clk) disable iff (!dig_ok)
        !conv_done |=> $stable(vcc_lo_flag)); // R8

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!dig_ok)
        dbg_state <= 3'd4); // R9

endmodule

bind supply_ready_ctrl chk_supply_ready_ctrl i_chk (.*);

// File: tb/test_supply_ready_ctrl.sv
module test_supply_ready_ctrl;
    localparam int unsigned DLY = 1024;

    logic       clk = 1'b0;
    logic       dig_ok = 1'b0, ana_ok = 1'b0, recall_done = 1'b0, conv_done = 1'b0;
    logic       supply_low_cmp = 1'b0, addr_from_store = 1'b0, single_dev = 1'b0;
    logic [6:0] stored_addr = 7'h3C;
    logic       recall_req, ready_n, vcc_lo_flag, aux_en, iface_en;
    logic [6:0] main_addr;
    logic [2:0] dbg_state;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    supply_ready_ctrl #(.READY_DELAY(DLY)) i_supply_ready_ctrl (.*);

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        dig_ok = 1'b0; single_dev = 1'b1; addr_from_store = 1'b1;
        step(2);
        chk("R1", "state", dbg_state, 0);
        chk("R1", "recall_req", recall_req, 0);
        chk("R1", "ready_n", ready_n, 1);
        chk("R1", "iface_en", iface_en, 0);
        chk("R1", "vcc_lo_flag", vcc_lo_flag, 1);
        chk("R1", "main_addr", main_addr, 'h51);
        chk("R1", "aux_en", aux_en, 1);
    endtask

    task automatic t_digital();
        dig_ok = 1'b1;
        step(1);
        chk("R2", "state", dbg_state, 1);
        chk("R2", "iface_en", iface_en, 1);
        step(5);
        chk("R2", "state held", dbg_state, 1);
        chk("R2", "recall_req", recall_req, 0);
    endtask

    task automatic t_recall_to_ready();
        ana_ok = 1'b1;
        step(1);
        chk("R3", "state", dbg_state, 2);
        chk("R3", "recall_req", recall_req, 1);
        chk("R6", "main before recall", main_addr, 'h51);
        chk("R7", "aux before recall", aux_en, 1);
        step(3);
        chk("R3", "waits for recall", dbg_state, 2);
        recall_done = 1'b1;
        step(1);
        recall_done = 1'b0;
        chk("R3", "state after recall", dbg_state, 3);
        chk("R3", "recall_req cleared", recall_req, 0);
        chk("R6", "main after recall", main_addr, 'h3C);
        chk("R7", "aux single mode", aux_en, 0);
        step(DLY - 1);
        chk("R4", "ready_n before expiry", ready_n, 1);
        chk("R4", "state before expiry", dbg_state, 3);
        step(1);
        chk("R4", "ready_n at expiry", ready_n, 0);
        chk("R9", "READY code", dbg_state, 4);
    endtask

    task automatic t_flag();
        chk("R8", "flag before conversion", vcc_lo_flag, 1);
        supply_low_cmp = 1'b0;
        step(2);
        chk("R8", "flag without strobe", vcc_lo_flag, 1);
        conv_done = 1'b1;
        step(1);
        conv_done = 1'b0;
        chk("R8", "flag after conv low", vcc_lo_flag, 0);
        supply_low_cmp = 1'b1;
        step(2);
        chk("R8", "flag ignores cmp", vcc_lo_flag, 0);
        conv_done = 1'b1;
        step(1);
        conv_done = 1'b0;
        chk("R8", "flag after conv high", vcc_lo_flag, 1);
    endtask

    task automatic t_drops();
        ana_ok = 1'b0;
        step(1);
        chk("R5", "drop from READY", dbg_state, 1);
        chk("R5", "ready_n after drop", ready_n, 1);
        chk("R6", "main kept", main_addr, 'h3C);
        chk("R7", "aux kept off", aux_en, 0);
        supply_low_cmp = 1'b0; conv_done = 1'b1;
        step(1);
        conv_done = 1'b0;
        chk("R8", "conv outside READY ignored", vcc_lo_flag, 1);
        ana_ok = 1'b1;
        step(1);
        chk("R5", "recall again", recall_req, 1);
        ana_ok = 1'b0;
        step(1);
        chk("R5", "drop from RECALLING", dbg_state, 1);
        ana_ok = 1'b1;
        step(1);
        recall_done = 1'b1;
        step(1);
        recall_done = 1'b0;
        chk("R9", "WAIT_READY code", dbg_state, 3);
        step(10);
        ana_ok = 1'b0;
        step(1);
        chk("R5", "drop from WAIT_READY", dbg_state, 1);
        chk("R5", "ready_n stays", ready_n, 1);
    endtask

    task automatic t_dig_loss_and_fixed();
        dig_ok = 1'b0;
        step(1);
        chk("R1", "state after loss", dbg_state, 0);
        chk("R6", "main default again", main_addr, 'h51);
        chk("R7", "aux back on", aux_en, 1);
        chk("R1", "flag reset", vcc_lo_flag, 1);
        addr_from_store = 1'b0; single_dev = 1'b0;
        dig_ok = 1'b1; ana_ok = 1'b1;
        step(2);
        chk("R3", "direct to RECALLING", dbg_state, 2);
        recall_done = 1'b1;
        step(1);
        recall_done = 1'b0;
        chk("R6", "fixed main address", main_addr, 'h51);
        chk("R7", "aux multi mode", aux_en, 1);
    endtask

    initial begin
        t_reset();
        t_digital();
        t_recall_to_ready();
        t_flag();
        t_drops();
        t_dig_loss_and_fixed();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule